// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by following a two-level page table kept in a word-addressed memory. A caller supplies the logical address together with the table base and the table length. The page number is split into an outer index, which selects a word in the outer table, and an inner index, which selects a word in the inner table page named by that outer word. The selected inner word holds the frame base, and the physical address is that base joined to the untouched page offset.

Before any memory read the walker checks the outer index against the length value. It also checks the valid flag of every entry it fetches. Each walk ends with a single-cycle completion strobe. The strobe carries either a physical address or a fault code, and the fault code tells the three failure causes apart. Reads go through a request/grant port with a separate response strobe, so the memory may take any number of cycles to grant and to answer.

Top module: `ptw_walker`

## Requirements
- R1: After reset `ready` is 1, and `done`, `mem_req` and `fault` are 0.
- R2: A request is taken only when `ready` is 1. A `req_valid` pulse during a walk has no effect on that walk's result or on the reads it makes.
- R3: If the outer index (logical address bits 31:20) is greater than or equal to `pt_len`, the walk ends with fault code 1 and makes no memory read. `done` rises in the cycle after the request is taken.
- R4: The first read goes to word address `pt_base + outer index`.
- R5: The second read goes to word address {outer entry bits 31:10, inner index}, where the inner index is logical address bits 19:10.
- R6: A walk that succeeds reports `fault` = 0, fault code 0 and `paddr` = {inner entry bits 31:10, logical address bits 9:0}.
- R7: An outer entry with bit 0 (the valid flag) clear ends the walk with fault code 2, and no second read is made.
- R8: An inner entry with bit 0 clear ends the walk with fault code 3 and `paddr` = 0.
- R9: `mem_req` stays high, with `mem_addr` unchanged, until `mem_gnt` is seen. Only one read is outstanding at a time.
- R10: `done` is high for exactly one cycle, and `ready` is 1 in the cycle after it.
- R11: After the last response, `done` rises in the cycle after the cycle in which `mem_rvalid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_laddr | input | 32 | Logical address to translate |
| pt_base | input | 32 | Word address of the outer table |
| pt_len | input | 13 | Number of valid outer entries |
| ready | output | 1 | Walker idle, able to take a request |
| done | output | 1 | Single-cycle completion strobe |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| paddr | output | 32 | Physical address, valid with `done` when `fault` is 0 |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory word address |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A length fault is due one cycle after the request edge. Every other ending is due one cycle after the edge that samples the final `mem_rvalid`. The bench counts rising edges and records the count at which its memory model raises `mem_rvalid`. It then requires `done` to appear at exactly that count plus one, or at the request count plus one for a length fault. All outputs are sampled on the falling edge, half a period after the register that drives them has updated. Stimulus and memory responses are also applied on the falling edge, so every check lands in a known cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_OUTER,
      ST_RD_INNER,
      ST_DONE,
      ST_FAULT
   } walk_st_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LEN   = 2'd1,
      FLT_OUTER = 2'd2,
      FLT_INNER = 2'd3
   } flt_e;
endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 10,
   localparam int OUTER_W = ADDR_W - 2 * OFFSET_W
) (
   input  logic [ADDR_W-1:0]   laddr,
   output logic [OUTER_W-1:0]  outer_idx,
   output logic [OFFSET_W-1:0] inner_idx,
   output logic [OFFSET_W-1:0] offset
);
   assign outer_idx = laddr[ADDR_W-1 -: OUTER_W];
   assign inner_idx = laddr[2*OFFSET_W-1 -: OFFSET_W];
   assign offset    = laddr[OFFSET_W-1:0];
endmodule

// File: rtl/ptw_mem_port.sv
module ptw_mem_port (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_active,
   input  logic mem_gnt,
   input  logic mem_rvalid,
   output logic mem_req,
   output logic rsp_valid
);
   logic pending;

   assign mem_req   = rd_active && !pending;
   assign rsp_valid = pending && mem_rvalid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pending <= 1'b0;
      else if (mem_req && mem_gnt) pending <= 1'b1;
      else if (rsp_valid)          pending <= 1'b0;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter int ADDR_W    = 32,
   parameter int OFFSET_W  = 10,
   parameter int VALID_BIT = 0,
   localparam int OUTER_W  = ADDR_W - 2 * OFFSET_W,
   localparam int LEN_W    = OUTER_W + 1,
   localparam int BASE_W   = ADDR_W - OFFSET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic [ADDR_W-1:0] pt_base,
   input  logic [LEN_W-1:0]  pt_len,
   output logic              ready,
   output logic              done,
   output logic              fault,
   output logic [1:0]        fault_code,
   output logic [ADDR_W-1:0] paddr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [ADDR_W-1:0] mem_rdata
);
   import ptw_pkg::*;

   if (OUTER_W < 1) begin : g_bad_split
      $error("ptw_walker: ADDR_W must exceed 2*OFFSET_W");
   end
   if (VALID_BIT >= OFFSET_W) begin : g_bad_valid
      $error("ptw_walker: VALID_BIT must lie inside the offset field");
   end

   walk_st_e            st;
   logic [ADDR_W-1:0]   laddr_q, base_q, paddr_q;
   logic [BASE_W-1:0]   tbl_q;
   logic [1:0]          code_q;
   logic [OUTER_W-1:0]  in_outer, q_outer;
   logic [OFFSET_W-1:0] in_inner, q_inner, in_off, q_off;
   logic                rd_active, rsp_valid, ent_ok, len_bad;

   ptw_addr_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) i_split_in (
      .laddr(req_laddr), .outer_idx(in_outer), .inner_idx(in_inner), .offset(in_off));

   ptw_addr_split #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) i_split_q (
      .laddr(laddr_q), .outer_idx(q_outer), .inner_idx(q_inner), .offset(q_off));

   assign rd_active = (st == ST_RD_OUTER) || (st == ST_RD_INNER);

   ptw_mem_port i_port (
      .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_req(mem_req), .rsp_valid(rsp_valid));

   assign len_bad = {1'b0, in_outer} >= pt_len;
   assign ent_ok  = mem_rdata[VALID_BIT];

   always_comb begin
      unique case (st)
         ST_RD_OUTER: mem_addr = base_q + ADDR_W'(q_outer);
         ST_RD_INNER: mem_addr = {tbl_q, q_inner};
         default:     mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         laddr_q <= '0;
         base_q  <= '0;
         tbl_q   <= '0;
         paddr_q <= '0;
         code_q  <= FLT_NONE;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               laddr_q <= req_laddr;
               base_q  <= pt_base;
               paddr_q <= '0;
               if (len_bad) begin
                  code_q <= FLT_LEN;
                  st     <= ST_FAULT;
               end else begin
                  code_q <= FLT_NONE;
                  st     <= ST_RD_OUTER;
               end
            end
            ST_RD_OUTER: if (rsp_valid) begin
               if (ent_ok) begin
                  tbl_q <= mem_rdata[ADDR_W-1:OFFSET_W];
                  st    <= ST_RD_INNER;
               end else begin
                  code_q <= FLT_OUTER;
                  st     <= ST_FAULT;
               end
            end
            ST_RD_INNER: if (rsp_valid) begin
               if (ent_ok) begin
                  paddr_q <= {mem_rdata[ADDR_W-1:OFFSET_W], q_off};
                  st      <= ST_DONE;
               end else begin
                  code_q <= FLT_INNER;
                  st     <= ST_FAULT;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ready      = (st == ST_IDLE);
   assign done       = (st == ST_DONE) || (st == ST_FAULT);
   assign fault      = (st == ST_FAULT);
   assign fault_code = code_q;
   assign paddr      = paddr_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 10,
   localparam int OUTER_W = ADDR_W - 2 * OFFSET_W,
   localparam int LEN_W   = OUTER_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_laddr,
   input logic [LEN_W-1:0]  pt_len,
   input logic              ready,
   input logic              done,
   input logic              fault,
   input logic [1:0]        fault_code,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_gnt
);
   logic len_hit;
   assign len_hit = {1'b0, req_laddr[ADDR_W-1 -: OUTER_W]} >= pt_len;

   p_len_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid && len_hit) |=> (done && fault && fault_code == 2'd1 && !mem_req));

   p_no_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !ready);

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready));

   p_code_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fault == (fault_code != 2'd0)));
endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
   .pt_len(pt_len), .ready(ready), .done(done), .fault(fault),
   .fault_code(fault_code), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt));

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_laddr = '0;
   logic [31:0] pt_base = '0;
   logic [12:0] pt_len = '0;
   logic        ready, done, fault, mem_req;
   logic [1:0]  fault_code;
   logic [31:0] paddr, mem_addr;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   int          gnt_dly = 0;
   int          rsp_lat = 0;
   logic [31:0] exp_oaddr, exp_iaddr, oent, ient;
   int          rd_cnt = 0;
   logic [31:0] rd_a0, rd_a1;
   int          rv_cyc = 0;
   bit          hold_err = 1'b0;

   ptw_walker i_ptw_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .pt_base(pt_base), .pt_len(pt_len), .ready(ready), .done(done),
      .fault(fault), .fault_code(fault_code), .paddr(paddr), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // memory model: grant after gnt_dly cycles, answer rsp_lat cycles later
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            logic [31:0] a;
            a = mem_addr;
            for (int i = 0; i < gnt_dly; i++) begin
               @(negedge clk);
               if (!mem_req || mem_addr !== a) hold_err = 1'b1;
            end
            if (rd_cnt == 0) rd_a0 = a; else rd_a1 = a;
            rd_cnt++;
            mem_gnt = 1'b1;
            @(negedge clk);
            mem_gnt = 1'b0;
            for (int i = 0; i < rsp_lat; i++) @(negedge clk);
            mem_rdata  = (a == exp_oaddr) ? oent : (a == exp_iaddr) ? ient : 32'hDEAD_0000;
            mem_rvalid = 1'b1;
            rv_cyc     = cyc;
            @(negedge clk);
            mem_rvalid = 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // one walk; returns cycle count at done
   task automatic walk(input logic [31:0] la, input logic [31:0] base,
                       input logic [12:0] len, input logic [31:0] oe,
                       input logic [31:0] ie, output int dcyc, output int t0);
      exp_oaddr = base + {20'b0, la[31:20]};
      exp_iaddr = {oe[31:10], la[19:10]};
      oent = oe; ient = ie;
      rd_cnt = 0; rd_a0 = '0; rd_a1 = '0; hold_err = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la; pt_base = base; pt_len = len;
      t0 = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 300 && !done; n++) @(negedge clk);
      dcyc = cyc;
   endtask

   task automatic after_done;
      @(negedge clk);
      chk(!done && ready, "R10", "done low and ready after strobe", {30'b0, done, ready}, 32'h1);
   endtask

   task automatic t_reset;
      chk(ready && !done && !mem_req && !fault, "R1", "reset outputs",
          {28'b0, ready, done, mem_req, fault}, 32'h8);
   endtask

   task automatic t_ok(input logic [31:0] la, input int g, input int l);
      int dc, t0;
      logic [31:0] oe, ie;
      gnt_dly = g; rsp_lat = l;
      oe = {22'h00ABC ^ {10'b0, la[31:20]}, 10'h001};
      ie = {22'h3F0F0 ^ {12'b0, la[19:10]}, 10'h3F1};
      walk(la, 32'h0000_1000, 13'd16, oe, ie, dc, t0);
      chk(rd_cnt == 2, "R5", "read count", rd_cnt, 2);
      chk(rd_a0 == 32'h0000_1000 + {20'b0, la[31:20]}, "R4", "outer read address", rd_a0,
          32'h0000_1000 + {20'b0, la[31:20]});
      chk(rd_a1 == {oe[31:10], la[19:10]}, "R5", "inner read address", rd_a1, {oe[31:10], la[19:10]});
      chk(done && !fault && fault_code == 2'd0, "R6", "success status", {29'b0, fault, fault_code}, 0);
      chk(paddr == {ie[31:10], la[9:0]}, "R6", "physical address", paddr, {ie[31:10], la[9:0]});
      chk(dc == rv_cyc + 1, "R11", "done cycle", dc, rv_cyc + 1);
      chk(!hold_err, "R9", "request held with stable address", {31'b0, hold_err}, 0);
      after_done();
   endtask

   task automatic t_len;
      int dc, t0;
      walk({12'd16, 10'd3, 10'd7}, 32'h0000_2000, 13'd16, 32'h1, 32'h1, dc, t0);
      chk(done && fault && fault_code == 2'd1, "R3", "length fault code", {30'b0, fault_code}, 1);
      chk(dc == t0 + 1, "R3", "length fault timing", dc, t0 + 1);
      chk(rd_cnt == 0, "R3", "no read on length fault", rd_cnt, 0);
      after_done();
      walk({12'd4095, 10'd0, 10'd0}, 32'h0, 13'd0, 32'h1, 32'h1, dc, t0);
      chk(fault_code == 2'd1 && rd_cnt == 0, "R3", "zero length faults", {30'b0, fault_code}, 1);
      after_done();
   endtask

   task automatic t_outer_bad;
      int dc, t0;
      gnt_dly = 1; rsp_lat = 2;
      walk({12'd2, 10'd9, 10'd9}, 32'h0000_0400, 13'd8, 32'hFFFF_FC00, 32'h1, dc, t0);
      chk(fault && fault_code == 2'd2, "R7", "outer invalid code", {30'b0, fault_code}, 2);
      chk(rd_cnt == 1, "R7", "no inner read", rd_cnt, 1);
      chk(dc == rv_cyc + 1, "R11", "outer fault timing", dc, rv_cyc + 1);
      after_done();
   endtask

   task automatic t_inner_bad;
      int dc, t0;
      gnt_dly = 0; rsp_lat = 0;
      walk({12'd1, 10'd1, 10'd1}, 32'h0000_0400, 13'd8, 32'h0001_2401, 32'hABCD_E3FE, dc, t0);
      chk(fault && fault_code == 2'd3, "R8", "inner invalid code", {30'b0, fault_code}, 3);
      chk(paddr == 32'h0, "R8", "paddr zero on fault", paddr, 0);
      chk(rd_cnt == 2, "R8", "two reads", rd_cnt, 2);
      after_done();
   endtask

   task automatic t_busy;
      int dc;
      logic [31:0] la, oe, ie;
      la = {12'd7, 10'd100, 10'h155};
      oe = 32'h0055_5401; ie = 32'h1234_5801;
      gnt_dly = 4; rsp_lat = 3;
      exp_oaddr = 32'h100 + 32'd7; exp_iaddr = {oe[31:10], la[19:10]};
      oent = oe; ient = ie;
      rd_cnt = 0; hold_err = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la; pt_base = 32'h100; pt_len = 13'd8;
      @(negedge clk);
      chk(!ready, "R2", "busy after take", {31'b0, ready}, 0);
      req_laddr = {12'd20, 10'd1, 10'd1}; pt_base = 32'h9000; pt_len = 13'd1;
      for (int i = 0; i < 3; i++) @(negedge clk);
      req_valid = 1'b0;
      for (int n = 0; n < 300 && !done; n++) @(negedge clk);
      dc = cyc;
      chk(!fault && paddr == {ie[31:10], la[9:0]}, "R2", "busy request ignored", paddr,
          {ie[31:10], la[9:0]});
      chk(rd_cnt == 2 && rd_a0 == 32'h107, "R2", "reads belong to first request", rd_a0, 32'h107);
      chk(dc == rv_cyc + 1, "R11", "busy walk timing", dc, rv_cyc + 1);
      after_done();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ok({12'd5, 10'd300, 10'h2A5}, 0, 0);
      t_ok({12'd15, 10'd1023, 10'h3FF}, 3, 5);
      t_ok({12'd0, 10'd0, 10'h000}, 1, 1);
      t_len();
      t_outer_bad();
      t_inner_bad();
      t_busy();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule